// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives asynchronous serial frames on a line that rests high. Each frame has one low start bit, eight data bits sent least significant bit first, one parity bit and one stop bit that should be high. The line passes through a synchronizer. Bit timing comes from an oversample tick that the surrounding logic supplies. Every bit is sampled at its midpoint. A start bit that is no longer low at its midpoint is treated as noise and dropped.

A finished frame is moved into a one-entry holding register. Four flags record the result: ready, overrun, parity error and framing error. Each type of error has its own rule for whether the data is loaded. The holding register works as a one-deep output stage. The ready flag is the valid signal and the ready-clear strobe is the acknowledge. There is no back-pressure on the line itself. A frame that completes while ready is still set is reported as an overrun, and its data is dropped. While any error flag is set, the receiver ignores new start bits. Host software clears the flags through the clear strobes. Two level interrupt requests, receive-complete and receive-error, share one enable input.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, ready, overrun, parity error and framing error are all 0. Both interrupt outputs are 0 and the holding register reads 0.
- R2: A valid frame loads its data bits into the holding register, with the first data bit on the line placed in bit 0, and sets ready to 1.
- R3: When par_odd is 0, the data bits and the parity bit together must contain an even number of ones. When par_odd is 1, they must contain an odd number of ones.
- R4: A parity mismatch sets the parity-error flag, still loads the data, and leaves ready at its value before the frame.
- R5: A stop bit sampled as 0 sets the framing-error flag, still loads the data, and leaves ready at its value before the frame.
- R6: A frame that completes while ready is 1 sets the overrun flag. The holding register is not changed and ready stays 1.
- R7: If one frame has several errors, all of the matching error flags are set in the same cycle.
- R8: While any of the three error flags is 1, start bits are ignored, and neither the holding register nor any flag changes.
- R9: A low level on the line that is gone by the middle of the start bit is rejected. No frame is received, and the next real frame is received correctly.
- R10: Each clear strobe sets only its own flag to 0. If a flag is set and cleared in the same cycle, the set wins.
- R11: irq_rxc equals rx_ie AND ready. irq_rxe equals rx_ie AND (overrun OR parity error OR framing error).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, asynchronous to clk, idle high |
| os_tick | input | 1 | Oversample enable, OSR ticks per bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_rdy | input | 1 | Clear strobe for the ready flag |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_per | input | 1 | Clear strobe for the parity-error flag |
| clr_fer | input | 1 | Clear strobe for the framing-error flag |
| rx_data | output | DATA_W | Holding register |
| rdy | output | 1 | Ready flag (valid for rx_data) |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity-error flag |
| frm_err | output | 1 | Framing-error flag |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_rxe | output | 1 | Receive-error interrupt request |

## Verification
The bench builds the block with DATA_W=8 and OSR=4 and holds the tick high on every cycle, so one bit lasts four clocks. This short bit time allows a sweep over all 256 data values under both parity modes, with the interrupt enable toggled across the sweep. Directed frames then cover each error rule, combined errors, the frozen state, the clear strobes and start-bit glitch rejection.

// File: rtl/uart_rx_stat_pkg.sv
package uart_rx_stat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // error flag vector bit positions
  localparam int unsigned ERR_FER = 0;
  localparam int unsigned ERR_PER = 1;
  localparam int unsigned ERR_OVR = 2;
  localparam int unsigned ERR_N   = 3;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b1;
        else        q[g] <= q[g-1];
      end
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              tick,
  input  logic              freeze,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_par,
  output logic              frm_stop
);
  localparam int unsigned CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned HALF  = OSR / 2;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              par_q, stop_q, done_q;
  logic              at_full;

  assign at_full = (cnt == FULL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      par_q  <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!rx_s && !freeze) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_full) begin
              cnt <= '0;
              sh  <= {rx_s, sh[DATA_W-1:1]};
              if (idx == LAST_IDX) st <= ST_PAR;
              else                 idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_full) begin
              cnt   <= '0;
              par_q <= rx_s;
              st    <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_full) begin
              cnt    <= '0;
              stop_q <= rx_s;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign frm_done = done_q;
  assign frm_data = sh;
  assign frm_par  = par_q;
  assign frm_stop = stop_q;

  AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && tick && cnt == MID_CNT && rx_s) |=> st == ST_IDLE); // R9
  AST_FROZEN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && freeze) |=> st == ST_IDLE); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_par,
  input  logic              frm_stop,
  input  logic              par_odd,
  input  logic              rx_ie,
  input  logic              clr_rdy,
  input  logic              clr_ovr,
  input  logic              clr_per,
  input  logic              clr_fer,
  output logic [DATA_W-1:0] hold,
  output logic              rdy,
  output logic [ERR_N-1:0]  err,
  output logic              freeze,
  output logic              irq_rxc,
  output logic              irq_rxe
);
  logic [DATA_W-1:0] hold_q;
  logic              rdy_q;
  logic [ERR_N-1:0]  err_q, err_set, err_clr;
  logic              par_bad, stop_bad, ovr_hit, load, good;

  assign par_bad  = ((^frm_data) ^ frm_par) != par_odd;
  assign stop_bad = !frm_stop;
  assign ovr_hit  = rdy_q;
  assign load     = frm_done && !ovr_hit;
  assign good     = load && !par_bad && !stop_bad;

  assign err_set[ERR_FER] = frm_done && stop_bad;
  assign err_set[ERR_PER] = frm_done && par_bad;
  assign err_set[ERR_OVR] = frm_done && ovr_hit;
  assign err_clr[ERR_FER] = clr_fer;
  assign err_clr[ERR_PER] = clr_per;
  assign err_clr[ERR_OVR] = clr_ovr;

  for (genvar k = 0; k < ERR_N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err_q[k] <= 1'b0;
      else if (err_set[k]) err_q[k] <= 1'b1;
      else if (err_clr[k]) err_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (load) hold_q <= frm_data;
      if (good)         rdy_q <= 1'b1;
      else if (clr_rdy) rdy_q <= 1'b0;
    end
  end

  assign hold    = hold_q;
  assign rdy     = rdy_q;
  assign err     = err_q;
  assign freeze  = |err_q;
  assign irq_rxc = rx_ie & rdy_q;
  assign irq_rxe = rx_ie & (|err_q);

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && rdy_q) |=> hold_q == $past(hold_q)); // R6
  AST_OVR_KEEPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && rdy_q && !clr_rdy) |=> (rdy_q && err_q[ERR_OVR])); // R6
  AST_ERR_STILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !rdy_q && !frm_stop) |=> (hold_q == $past(frm_data) && !rdy_q)); // R5
  AST_FRAME_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_stop) |=> err_q[ERR_FER]); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> (!irq_rxc && !irq_rxe)); // R11
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              par_odd,
  input  logic              rx_ie,
  input  logic              clr_rdy,
  input  logic              clr_ovr,
  input  logic              clr_per,
  input  logic              clr_fer,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              irq_rxc,
  output logic              irq_rxe
);
  logic              rx_s, freeze, frm_done, frm_par, frm_stop;
  logic [DATA_W-1:0] frm_data;
  logic [ERR_N-1:0]  err;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(os_tick), .freeze(freeze),
    .frm_done(frm_done), .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_data(frm_data),
    .frm_par(frm_par), .frm_stop(frm_stop), .par_odd(par_odd), .rx_ie(rx_ie),
    .clr_rdy(clr_rdy), .clr_ovr(clr_ovr), .clr_per(clr_per), .clr_fer(clr_fer),
    .hold(rx_data), .rdy(rdy), .err(err), .freeze(freeze),
    .irq_rxc(irq_rxc), .irq_rxe(irq_rxe)
  );

  assign ovr_err = err[ERR_OVR];
  assign par_err = err[ERR_PER];
  assign frm_err = err[ERR_FER];
endmodule

// File: tb/uart_rx_stat_test.sv
module uart_rx_stat_test;
  localparam int unsigned DW  = 8;
  localparam int unsigned OSR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, os_tick = 1'b1, par_odd = 1'b0, rx_ie = 1'b0;
  logic clr_rdy = 1'b0, clr_ovr = 1'b0, clr_per = 1'b0, clr_fer = 1'b0;
  logic [DW-1:0] rx_data;
  logic rdy, ovr_err, par_err, frm_err, irq_rxc, irq_rxe;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  uart_rx_stat #(.DATA_W(DW), .OSR(OSR)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .par_odd(par_odd),
    .rx_ie(rx_ie), .clr_rdy(clr_rdy), .clr_ovr(clr_ovr), .clr_per(clr_per),
    .clr_fer(clr_fer), .rx_data(rx_data), .rdy(rdy), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err), .irq_rxc(irq_rxc), .irq_rxe(irq_rxe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic pb, input logic sb);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    send_bit(pb);
    send_bit(sb);
    rxd = 1'b1;
    repeat (3 * OSR) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic pulse(input int which);
    case (which)
      0: clr_rdy = 1'b1;
      1: clr_ovr = 1'b1;
      2: clr_per = 1'b1;
      default: clr_fer = 1'b1;
    endcase
    @(negedge clk);
    clr_rdy = 1'b0; clr_ovr = 1'b0; clr_per = 1'b0; clr_fer = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] flags();
    return {28'd0, rdy, ovr_err, par_err, frm_err};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", flags(), 32'h0);
    check("R1 irqs", {30'd0, irq_rxc, irq_rxe}, 32'h0);
    check("R1 data", 32'(rx_data), 32'h0);

    // R2/R3/R11 sweep over every byte and both parity modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [DW-1:0] b;
        b = DW'(v);
        par_odd = m[0];
        rx_ie = b[0] ^ m[0];
        send_frame(b, good_par(b, m[0]), 1'b1);
        check("R2 data", 32'(rx_data), 32'(b));
        check("R3 flags", flags(), 32'h8);
        check("R11 irqs", {30'd0, irq_rxc, irq_rxe}, {30'd0, rx_ie, 1'b0});
        pulse(0);
      end
    end
    par_odd = 1'b0;
    rx_ie = 1'b1;

    // R4 parity error
    send_frame(8'h5A, ~good_par(8'h5A, 1'b0), 1'b1);
    check("R4 flags", flags(), 32'h2);
    check("R4 data", 32'(rx_data), 32'h5A);
    check("R11 err irq", {30'd0, irq_rxc, irq_rxe}, 32'h1);
    // R8 frozen
    send_frame(8'h33, good_par(8'h33, 1'b0), 1'b1);
    check("R8 data", 32'(rx_data), 32'h5A);
    check("R8 flags", flags(), 32'h2);
    // R10 clear parity only
    pulse(2);
    check("R10 per clear", flags(), 32'h0);
    send_frame(8'hC3, good_par(8'hC3, 1'b0), 1'b1);
    check("R8 resume", 32'(rx_data), 32'hC3);
    // R6 overrun
    send_frame(8'h81, good_par(8'h81, 1'b0), 1'b1);
    check("R6 flags", flags(), 32'hC);
    check("R6 data", 32'(rx_data), 32'hC3);
    check("R11 both irqs", {30'd0, irq_rxc, irq_rxe}, 32'h3);
    pulse(1);
    check("R10 ovr clear", flags(), 32'h8);
    pulse(0);
    check("R10 rdy clear", flags(), 32'h0);
    // R5 framing error
    send_frame(8'h7E, good_par(8'h7E, 1'b0), 1'b0);
    check("R5 flags", flags(), 32'h1);
    check("R5 data", 32'(rx_data), 32'h7E);
    pulse(3);
    check("R10 fer clear", flags(), 32'h0);
    // R7 combined errors on top of overrun
    send_frame(8'h11, good_par(8'h11, 1'b0), 1'b1);
    send_frame(8'h22, ~good_par(8'h22, 1'b0), 1'b0);
    check("R7 flags", flags(), 32'hF);
    check("R7 data", 32'(rx_data), 32'h11);
    rx_ie = 1'b0;
    @(negedge clk);
    check("R11 masked", {30'd0, irq_rxc, irq_rxe}, 32'h0);
    rx_ie = 1'b1;
    pulse(1); pulse(2); pulse(3); pulse(0);
    check("R10 all clear", flags(), 32'h0);
    // R9 start glitch
    rxd = 1'b0;
    @(negedge clk);
    rxd = 1'b1;
    repeat (4 * OSR) @(negedge clk);
    check("R9 glitch flags", flags(), 32'h0);
    send_frame(8'h96, good_par(8'h96, 1'b0), 1'b1);
    check("R9 next frame", 32'(rx_data), 32'h96);
    check("R9 next flags", flags(), 32'h8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule